// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers a group of peripheral interrupt request lines and one unmaskable error input into a single interrupt line to the processor. Each ordinary line is captured on its rising edge and held as pending. A software-written mask keeps chosen lines from raising the interrupt, but the captured request is not lost. Pending, unmasked lines compete under either fixed or rotating priority. The winner is offered to the processor as a vector index, which the processor uses to look up the handler address in its vector table.

The offer follows a valid/ready handshake. `int_o` is the valid signal, `vec_o` is the payload and `ack_i` is the ready signal. A grant takes place on a clock edge where `int_o` and `ack_i` are both high. Before that edge the offer stays up, but the vector is resolved again every cycle, so a higher-priority arrival or a mask write can change `vec_o` or drop `int_o`. An `ack_i` while `int_o` is low does nothing.

After a grant, the source is in service and every further ordinary request waits until the processor pulses `eos_i`. The unmaskable input can still break in. Services therefore nest at most two deep, and each `eos_i` pulse closes the innermost one first.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `int_o` is 0, `vec_o` is 0, the mask is all zeros (every line enabled), nothing is pending and nothing is in service.
- R2: A line becomes pending on a 0-to-1 transition of its input. Holding the input high after its grant makes no new request; a new request needs the line to fall and rise again.
- R3: In fixed mode (`rotate_i`=0), the lowest-numbered eligible line wins.
- R4: In rotating mode (`rotate_i`=1), the search starts at the line after the one most recently granted and wraps around, so the line just served has the lowest priority.
- R5: When a line's mask bit is 1, its pending request does not assert `int_o`, but it stays latched. Clearing the mask bit (write `mask_we_i`=1 with new `mask_wdata_i`) lets it through.
- R6: The unmaskable input is captured on its rising edge and ignores the mask. While it is pending and not already in service, it beats every ordinary line and shows vector index N (8 with default parameters).
- R7: From the grant of an ordinary line until `eos_i`, `int_o` stays low for every ordinary request, and those requests stay pending.
- R8: The unmaskable request may be granted while an ordinary line is in service. The first `eos_i` then ends the unmaskable service and the second ends the ordinary one. Ordinary requests wait until both have ended.
- R9: A grant clears the winner's pending bit on the grant edge. An `ack_i` while `int_o` is low changes no state.
- R10: `vec_o` carries the line number i for ordinary line i, carries N for the unmaskable input, and is 0 whenever `int_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | N | Ordinary request lines, rising-edge sensitive |
| nmi_i | input | 1 | Unmaskable error request, rising-edge sensitive |
| rotate_i | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | N | New mask value; 1 blocks the line |
| ack_i | input | 1 | Processor ready or acknowledge |
| eos_i | input | 1 | End-of-service strobe |
| int_o | output | 1 | Interrupt request to the processor (valid) |
| vec_o | output | $clog2(N+1) | Vector index of the current winner |

## Verification
The bench goes after the nesting order. A design that let either end-of-service pulse release an ordinary request while the unmaskable service was still open would raise `int_o` one pulse too early. It also goes after level versus edge capture: a design that latches levels would grant a held line again forever. Further checks cover a masked request that must survive until it is unmasked, and an acknowledge with no offer. A design that treats that stray acknowledge as a grant would put a phantom line in service and block the next request. Finally, the bench follows the rotating pointer through a wrap-around, where an off-by-one pointer picks the wrong line.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] lvl_q;
  logic [W-1:0] rise;

  assign rise = lvl_i & ~lvl_q;

  // clear takes precedence over a rise seen in the same cycle
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_o <= '0;
    end else begin
      lvl_q  <= lvl_i;
      pend_o <= (pend_o | rise) & ~clr_i;
    end
  end

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_o) & ~$past(clr_i) & ~pend_o) == '0)); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(clr_i)) == '0)); // R9
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic          rotate_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  import pic_pkg::*;

  prio_mode_e mode;
  int         base;
  int         k;

  assign mode = prio_mode_e'(rotate_i);

  // search starts at base and wraps; base is 0 in fixed mode
  always_comb begin
    base    = (mode == PRIO_ROTATE) ? ((int'(last_i) + 1) % N) : 0;
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    k       = 0;
    for (int i = 0; i < N; i++) begin
      k = (base + i) % N;
      if (!any_o && req_i[k]) begin
        any_o      = 1'b1;
        grant_o[k] = 1'b1;
        idx_o      = IW'(k);
      end
    end
  end
endmodule

// File: rtl/pic_service.sv
module pic_service #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_ord_i,
  input  logic          ack_nmi_i,
  input  logic [IW-1:0] ack_idx_i,
  input  logic          eos_i,
  output logic          ord_svc_o,
  output logic          nmi_svc_o,
  output logic [IW-1:0] last_o
);
  // end of service closes the innermost level first
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ord_svc_o <= 1'b0;
      nmi_svc_o <= 1'b0;
      last_o    <= IW'(N - 1);
    end else begin
      if (ack_nmi_i)
        nmi_svc_o <= 1'b1;
      else if (eos_i && nmi_svc_o)
        nmi_svc_o <= 1'b0;

      if (ack_ord_i) begin
        ord_svc_o <= 1'b1;
        last_o    <= ack_idx_i;
      end else if (eos_i && !nmi_svc_o) begin
        ord_svc_o <= 1'b0;
      end
    end
  end

  AST_ORD_SVC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ord_i |=> ord_svc_o); // R7
  AST_NMI_SVC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_nmi_i |=> nmi_svc_o); // R8
  AST_EOS_NESTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && nmi_svc_o && !ack_ord_i) |=> $stable(ord_svc_o)); // R8
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int N = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N-1:0]           irq_i,
  input  logic                   nmi_i,
  input  logic                   rotate_i,
  input  logic                   mask_we_i,
  input  logic [N-1:0]           mask_wdata_i,
  input  logic                   ack_i,
  input  logic                   eos_i,
  output logic                   int_o,
  output logic [$clog2(N+1)-1:0] vec_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int VW = $clog2(N + 1);

  logic [N-1:0]  mask_q;
  logic [N-1:0]  pend;
  logic [N-1:0]  elig;
  logic [N-1:0]  grant;
  logic [N-1:0]  ord_clr;
  logic [IW-1:0] win_idx;
  logic [IW-1:0] last_idx;
  logic          any_ord;
  logic          nmi_pend;
  logic          nmi_win;
  logic          ord_svc;
  logic          nmi_svc;
  logic          fire;
  logic          ack_ord;
  logic          ack_nmi;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  pic_req_latch #(.W(N)) u_ord_latch (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(irq_i), .clr_i(ord_clr), .pend_o(pend)
  );

  pic_req_latch #(.W(1)) u_nmi_latch (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(nmi_i), .clr_i(ack_nmi), .pend_o(nmi_pend)
  );

  // ordinary lines wait while any service level is open
  assign elig = pend & ~mask_q & {N{~(ord_svc | nmi_svc)}};

  pic_arbiter #(.N(N), .IW(IW)) u_arb (
    .req_i(elig), .rotate_i(rotate_i), .last_i(last_idx),
    .grant_o(grant), .idx_o(win_idx), .any_o(any_ord)
  );

  assign nmi_win = nmi_pend & ~nmi_svc;
  assign int_o   = nmi_win | any_ord;
  assign vec_o   = nmi_win ? VW'(N) : (any_ord ? VW'(win_idx) : '0);

  assign fire    = ack_i & int_o;
  assign ack_nmi = fire & nmi_win;
  assign ack_ord = fire & ~nmi_win;
  assign ord_clr = ack_ord ? grant : '0;

  pic_service #(.N(N), .IW(IW)) u_svc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_ord_i(ack_ord), .ack_nmi_i(ack_nmi),
    .ack_idx_i(win_idx), .eos_i(eos_i), .ord_svc_o(ord_svc), .nmi_svc_o(nmi_svc),
    .last_o(last_idx)
  );

  AST_NMI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend && !nmi_svc) |-> (int_o && vec_o == VW'(N))); // R6
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ord_svc || nmi_svc) && !nmi_pend) |-> !int_o); // R7
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R3
  AST_MASK_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_pend && ((pend & ~mask_q) == '0)) |-> !int_o); // R5
  AST_IDLE_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_o |-> (vec_o == '0)); // R10
endmodule

// File: tb/pic_ctrl_tb.sv
`timescale 1ns/1ps
module pic_ctrl_tb;
  localparam int N  = 8;
  localparam int VW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq;
  logic          nmi, rot, mwe, ack, eos;
  logic [N-1:0]  mdat;
  logic          int_o;
  logic [VW-1:0] vec;

  int    n_chk = 0;
  int    n_err = 0;
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  pic_ctrl #(.N(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi), .rotate_i(rot),
    .mask_we_i(mwe), .mask_wdata_i(mdat), .ack_i(ack), .eos_i(eos),
    .int_o(int_o), .vec_o(vec)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each completed handshake
  always @(negedge clk) begin
    #1;
    if (ack && int_o) begin
      if (exp_q.size() == 0) check(1'b0, "SCB-extra", int'(vec), -1);
      else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(int'(vec) == e, t, int'(vec), e);
      end
    end
  end

  task automatic serve(input int e, input string t);
    int w;
    exp_q.push_back(e);
    tag_q.push_back(t);
    w = 0;
    while (!int_o && w < 50) begin @(negedge clk); w++; end
    if (!int_o) begin
      check(1'b0, {t, "-timeout"}, 0, 1);
      void'(exp_q.pop_back());
      void'(tag_q.pop_back());
    end else begin
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
    end
  endtask

  task automatic end_svc();
    eos = 1'b1; @(negedge clk); eos = 1'b0; @(negedge clk);
  endtask

  task automatic set_irq(input logic [N-1:0] v);
    irq = v; @(negedge clk); @(negedge clk);
  endtask

  task automatic set_nmi(input logic v);
    nmi = v; @(negedge clk); @(negedge clk);
  endtask

  task automatic wr_mask(input logic [N-1:0] v);
    mwe = 1'b1; mdat = v; @(negedge clk); mwe = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq = '0; nmi = 0; rot = 0; mwe = 0; mdat = '0; ack = 0; eos = 0;
    repeat (3) @(negedge clk);
    check(int_o == 1'b0, "R1 int in reset", int'(int_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(int_o == 1'b0, "R1 int after reset", int'(int_o), 0);
    check(vec == '0, "R1 vec after reset", int'(vec), 0);

    // fixed priority and hold-off
    set_irq(8'h24);
    serve(2, "R3 fixed low index wins");
    check(int_o == 1'b0, "R7 held off in service", int'(int_o), 0);
    end_svc();
    check(int_o == 1'b1 && vec == 4'd5, "R7 released after eos", int'(vec), 5);
    serve(5, "R10 vector of line 5");
    end_svc();
    check(int_o == 1'b0, "R2 held level no rerequest", int'(int_o), 0);
    set_irq('0);

    // stray ack
    ack = 1'b1; @(negedge clk); ack = 1'b0; @(negedge clk);
    set_irq(8'h08);
    check(int_o == 1'b1 && vec == 4'd3, "R9 stray ack ignored", int'(vec), 3);
    serve(3, "R9 line 3");
    end_svc();
    check(int_o == 1'b0, "R9 pending cleared", int'(int_o), 0);
    set_irq('0);

    // masking
    wr_mask(8'h10);
    set_irq(8'h10);
    check(int_o == 1'b0, "R5 masked no int", int'(int_o), 0);
    wr_mask(8'h00);
    check(int_o == 1'b1 && vec == 4'd4, "R5 latched through mask", int'(vec), 4);
    serve(4, "R5 line 4");
    end_svc();
    set_irq('0);

    // unmaskable input
    wr_mask(8'hFF);
    irq = 8'h02;
    set_nmi(1'b1);
    check(int_o == 1'b1 && vec == 4'd8, "R6 nmi ignores mask", int'(vec), 8);
    serve(8, "R6 nmi vector");
    end_svc();
    check(int_o == 1'b0, "R5 masked after nmi", int'(int_o), 0);
    wr_mask(8'h00);
    serve(1, "R5 line 1 after unmask");
    end_svc();
    set_irq('0);
    set_nmi(1'b0);

    // pre-emption and nesting
    set_irq(8'h40);
    serve(6, "R8 line 6");
    set_nmi(1'b1);
    check(int_o == 1'b1 && vec == 4'd8, "R8 nmi preempts", int'(vec), 8);
    serve(8, "R8 nmi grant");
    set_irq(8'h41);
    check(int_o == 1'b0, "R7 ordinary blocked nested", int'(int_o), 0);
    end_svc();
    check(int_o == 1'b0, "R8 first eos ends nmi only", int'(int_o), 0);
    end_svc();
    check(int_o == 1'b1 && vec == 4'd0, "R8 second eos ends ordinary", int'(vec), 0);
    serve(0, "R8 line 0");
    end_svc();
    set_irq('0);
    set_nmi(1'b0);

    // rotating priority, last granted was line 0
    rot = 1'b1;
    set_irq(8'h89);
    serve(3, "R4 start after last");
    end_svc();
    serve(7, "R4 next after 3");
    end_svc();
    serve(0, "R4 wrap to 0");
    end_svc();
    set_irq('0);
    set_irq(8'h03);
    serve(1, "R4 just served lowest");
    end_svc();
    serve(0, "R4 wrap again");
    end_svc();
    set_irq('0);

    rot = 1'b0;
    set_irq(8'h42);
    serve(1, "R3 fixed after rotate");
    end_svc();
    serve(6, "R3 then line 6");
    end_svc();
    set_irq('0);
    check(int_o == 1'b0 && vec == '0, "R10 idle vector zero", int'(vec), 0);
    check(exp_q.size() == 0, "SCB drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule